// File: doc/BRIEF.md
# Split serial access register

This block is the serial side of a video memory: a 512-word register, 4 bits per word, that is filled from one row of the memory array in a single transfer and then clocked out one word at a time by a serial clock. A full transfer replaces all 512 words and places the serial pointer at the requested start word (the tap). A split transfer refills only the half that is not being shifted out. It records a tap inside that half, and shifting continues without a break. When the pointer leaves the last word of a half, it moves to the other half. If a split transfer refilled that half in the meantime, the pointer lands on the recorded tap. Otherwise it lands on the first word of that half.

A transfer is requested by a one-cycle strobe together with an enable. A strobe whose enable is low does nothing. The serial clock is sampled in the system clock domain, and each rising edge outputs one word. A flag output shows which half holds the word that will be output next. The array behind the register is modelled by a fixed content rule, so that a row can be loaded without a storage array of 512 rows.

Top module: `split_serial_reg`

## Requirements
- R1: After reset, `sdata` is 0, `half_flag` is 0, every register word is 0 and the pointer is at word 0.
- R2: A strobe with `xfer_en`=1 and `xfer_split`=0 (full transfer) loads all 512 words from row `row_addr`, sets the pointer to `tap_addr` and cancels any pending split. `half_flag` then equals `tap_addr[8]` one cycle after the strobe.
- R3: After a transfer, `sdata` keeps its value until the next rising edge of `sclk`. That edge outputs the word at the tap, and each later rising edge outputs the next word. `sdata` changes in the clock cycle in which the rising edge of `sclk` is first sampled.
- R4: In full-register use, the pointer goes from word 511 to word 0, and `half_flag` toggles at that step.
- R5: A strobe with `xfer_en`=0 leaves the register words, the pointer, `half_flag` and `sdata` unchanged.
- R6: A strobe with `xfer_en`=1 and `xfer_split`=1 (split transfer) loads only the half that does not contain the pointer (words 0..255 when the pointer is in 256..511, otherwise words 256..511). It leaves the other half, the pointer, `half_flag` and `sdata` unchanged.
- R7: When a word at offset 255 of a half is output and no split is pending, the pointer moves to word 256 (from the lower half) or to word 0 (from the upper half).
- R8: When a split is pending at that step, the pointer moves to the other half at offset `tap_addr[7:0]` of the split request, and the pending state clears. `tap_addr[8]` of a split request is ignored.
- R9: `half_flag` is 1 exactly when the next word to be output lies in words 256..511. It toggles only on a boundary step or on a full transfer.
- R10: A full transfer in the same cycle as a rising `sclk` edge takes priority: the shift is dropped and `sdata` holds its value.
- R11: A split transfer in the same cycle as a boundary step loads the half being entered, and that same step already lands on the new tap.
- R12: Array content: word c of row r is (5·r + c + 3·floor(c/16)) mod 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_stb | input | 1 | One-cycle transfer strobe (row cycle start) |
| xfer_en | input | 1 | 1 = perform a transfer on this strobe |
| xfer_split | input | 1 | 1 = split transfer, 0 = full transfer |
| row_addr | input | 9 | Row to transfer |
| tap_addr | input | 9 | Start word; bit 8 ignored in split transfers |
| sclk | input | 1 | Serial clock, sampled on `clk` |
| sdata | output | 4 | Serial output word |
| half_flag | output | 1 | Half holding the next word to output |

## Verification
Two functions can fall in the same cycle here. A transfer can coincide with a serial shift: a full transfer against a rising `sclk` edge, and a split transfer against the step that leaves a half. Directed sequences place the pointer at offset 255 of a half and then raise `sclk` in the same cycle as the strobe. A constrained random run with taps biased near the half boundary provokes the same collisions again and again. Every cycle, the bench compares `sdata` and `half_flag` against a reference built from the requirements. That reference resolves collisions by R10 and R11 and checks the next words shifted out for the content of the right row.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;

  // Stand-in for the array contents: word col of row row.
  function automatic int unsigned cell_val(input int unsigned row, input int unsigned col);
    return row * 5 + col + 3 * (col >> 4);
  endfunction

endpackage

// File: rtl/sar_front.sv
`timescale 1ns/1ps
module sar_front (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rst_sync_n,
  output logic sc_rise
);
  logic [1:0] rs_q, rs_d;
  logic       sc_q, sc_d;

  assign rs_d = {rs_q[0], 1'b1};
  assign sc_d = sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= rs_d;
  end

  assign rst_sync_n = rs_q[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sc_q <= 1'b0;
    else             sc_q <= sc_d;
  end

  assign sc_rise = sclk & ~sc_q;

  // R3: one shift per serial clock pulse
  a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sc_rise |=> !sc_rise);
endmodule

// File: rtl/sar_ptr_ctrl.sv
`timescale 1ns/1ps
module sar_ptr_ctrl #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_ld,
  input  logic          split_ld,
  input  logic          shift,
  input  logic [AW-1:0] tap,
  output logic [AW-1:0] ptr
);
  localparam int HW = AW - 1;

  logic [AW-1:0] ptr_q, ptr_d;
  logic          pend_q, pend_d;
  logic [HW-1:0] ptap_q, ptap_d;
  logic          at_end;
  logic          jump_pend;
  logic [HW-1:0] jump_low;

  assign at_end    = &ptr_q[HW-1:0];
  assign jump_pend = split_ld | pend_q;
  assign jump_low  = split_ld ? tap[HW-1:0] : ptap_q;

  always_comb begin
    ptr_d  = ptr_q;
    pend_d = pend_q;
    ptap_d = ptap_q;
    if (full_ld) begin
      ptr_d  = tap;
      pend_d = 1'b0;
    end else begin
      if (split_ld) begin
        pend_d = 1'b1;
        ptap_d = tap[HW-1:0];
      end
      if (shift) begin
        if (at_end) begin
          ptr_d  = {~ptr_q[AW-1], (jump_pend ? jump_low : {HW{1'b0}})};
          pend_d = 1'b0;
        end else begin
          ptr_d = ptr_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      pend_q <= 1'b0;
      ptap_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      pend_q <= pend_d;
      ptap_q <= ptap_d;
    end
  end

  assign ptr = ptr_q;

  // R2: full transfer places the pointer at the tap and drops a pending split
  a_r2_full_tap: assert property (@(posedge clk) disable iff (!rst_n)
    full_ld |=> (ptr_q == $past(tap)) && !pend_q);
  // R6: split transfer without a shift leaves the pointer in place
  a_r6_split_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (split_ld && !shift && !full_ld) |=> $stable(ptr_q));
  // R7: boundary without pending split lands on the first word of the other half
  a_r7_half_start: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && at_end && !pend_q && !split_ld && !full_ld) |=> (ptr_q[HW-1:0] == '0));
  // R8: boundary with pending split lands on the recorded tap
  a_r8_pending_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && at_end && pend_q && !split_ld && !full_ld) |=> (ptr_q[HW-1:0] == $past(ptap_q)) && !pend_q);
  // R9: half changes on every boundary step
  a_r9_half_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && at_end && !full_ld) |=> (ptr_q[AW-1] != $past(ptr_q[AW-1])));
  // R9: half is kept on inner steps
  a_r9_half_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_ld && !(shift && at_end)) |=> $stable(ptr_q[AW-1]));
endmodule

// File: rtl/sar_store.sv
`timescale 1ns/1ps
module sar_store
  import sar_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 4,
  parameter int ROW_W  = 9,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_ld,
  input  logic              split_ld,
  input  logic              shift,
  input  logic [ROW_W-1:0]  row,
  input  logic [AW-1:0]     ptr,
  output logic [DATA_W-1:0] sdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [DEPTH-1:0]  ld_w;
  logic [DATA_W-1:0] sd_q, sd_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ld
    localparam bit UPPER = (g >= DEPTH / 2);
    assign ld_w[g] = full_ld | (split_ld & (ptr[AW-1] != UPPER));
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ld_w[i]) mem_d[i] = DATA_W'(cell_val(int'(row), i));
      else         mem_d[i] = mem_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign sd_d = shift ? mem_q[ptr] : sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_q <= '0;
    else        sd_q <= sd_d;
  end

  assign sdata = sd_q;

  // R10: output holds while a full transfer is taken
  a_r10_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    full_ld |=> $stable(sd_q));
  // R6: the word under the pointer survives a split transfer
  a_r6_active_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (split_ld && !full_ld) |=> (mem_q[$past(ptr)] == $past(mem_q[ptr])));
  // R3: output changes only on a shift
  a_r3_hold_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(sd_q));
endmodule

// File: rtl/split_serial_reg.sv
`timescale 1ns/1ps
module split_serial_reg #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 4,
  parameter int ROW_W  = 9,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_stb,
  input  logic              xfer_en,
  input  logic              xfer_split,
  input  logic [ROW_W-1:0]  row_addr,
  input  logic [AW-1:0]     tap_addr,
  input  logic              sclk,
  output logic [DATA_W-1:0] sdata,
  output logic              half_flag
);
  logic          rst_sync_n;
  logic          sc_rise;
  logic          full_ld, split_ld, shift;
  logic [AW-1:0] ptr;

  sar_front i_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .rst_sync_n (rst_sync_n),
    .sc_rise    (sc_rise)
  );

  assign full_ld  = xfer_stb & xfer_en & ~xfer_split;
  assign split_ld = xfer_stb & xfer_en &  xfer_split;
  assign shift    = sc_rise & ~full_ld;

  sar_ptr_ctrl #(.AW(AW)) i_ptr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .full_ld  (full_ld),
    .split_ld (split_ld),
    .shift    (shift),
    .tap      (tap_addr),
    .ptr      (ptr)
  );

  sar_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ROW_W(ROW_W), .AW(AW)) i_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .full_ld  (full_ld),
    .split_ld (split_ld),
    .shift    (shift),
    .row      (row_addr),
    .ptr      (ptr),
    .sdata    (sdata)
  );

  assign half_flag = ptr[AW-1];

  // R5: a strobe without enable changes nothing visible
  a_r5_no_xfer: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xfer_stb && !xfer_en && !sc_rise) |=> $stable(half_flag) && $stable(sdata));
endmodule

// File: tb/test_split_serial_reg.sv
`timescale 1ns/1ps
module test_split_serial_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       xfer_stb, xfer_en, xfer_split, sclk;
  logic [8:0] row_addr, tap_addr;
  logic [3:0] sdata;
  logic       half_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_mem [512];
  int m_ptr, m_ptap, m_sdata;
  bit m_pend, m_prev_sc;

  always #2.5 clk = ~clk;

  split_serial_reg i_split_serial_reg (
    .clk(clk), .rst_n(rst_n), .xfer_stb(xfer_stb), .xfer_en(xfer_en),
    .xfer_split(xfer_split), .row_addr(row_addr), .tap_addr(tap_addr),
    .sclk(sclk), .sdata(sdata), .half_flag(half_flag)
  );

  // R12: content rule of the array
  function automatic int exp_cell(input int r, input int c);
    return (r * 5 + c + 3 * (c / 16)) % 16;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d time=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Apply one cycle of stimulus, update the reference, compare the outputs.
  task automatic step(input bit stb, input bit en, input bit spl,
                      input int row, input int tap, input bit sc, input string tag);
    bit rise, full, sp, shf;
    int old;
    @(negedge clk);
    xfer_stb = stb; xfer_en = en; xfer_split = spl;
    row_addr = 9'(row); tap_addr = 9'(tap); sclk = sc;
    @(posedge clk);
    #1;
    rise = sc && !m_prev_sc;
    m_prev_sc = sc;
    full = stb && en && !spl;
    sp   = stb && en && spl;
    shf  = rise && !full;
    old  = m_ptr;
    if (shf) m_sdata = m_mem[old];
    if (full) begin
      for (int c = 0; c < 512; c++) m_mem[c] = exp_cell(row, c);
      m_ptr  = tap;
      m_pend = 1'b0;
    end else begin
      if (sp) begin
        for (int c = 0; c < 256; c++) m_mem[(old >= 256 ? 0 : 256) + c] = exp_cell(row, (old >= 256 ? 0 : 256) + c);
        m_pend = 1'b1;
        m_ptap = tap % 256;
      end
      if (shf) begin
        if (old % 256 == 255) begin
          m_ptr  = (old >= 256 ? 0 : 256) + (m_pend ? m_ptap : 0);
          m_pend = 1'b0;
        end else begin
          m_ptr = old + 1;
        end
      end
    end
    check(tag, "sdata", int'(sdata), m_sdata);
    check(tag, "half_flag", int'(half_flag), (m_ptr >= 256) ? 1 : 0);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic shifts(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, 0, 0, 1, tag);
      step(0, 0, 0, 0, 0, 0, tag);
    end
  endtask

  initial begin
    int seed;
    int tap;
    seed = $urandom(32'd2024);
    rst_n = 1'b0;
    xfer_stb = 0; xfer_en = 0; xfer_split = 0; row_addr = '0; tap_addr = '0; sclk = 0;
    for (int c = 0; c < 512; c++) m_mem[c] = 0;
    m_ptr = 0; m_ptap = 0; m_sdata = 0; m_pend = 0; m_prev_sc = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1", "sdata", int'(sdata), 0);
    check("R1", "half_flag", int'(half_flag), 0);
    shifts(3, "R1");

    // R2, R3: full transfer, output held until the next serial edge
    step(1, 1, 0, 3, 250, 0, "R2");
    idle(3, "R3");
    // R7, R9: cross from lower to upper half with nothing pending
    shifts(12, "R7");

    // R4: wrap from 511 to 0
    step(1, 1, 0, 7, 505, 0, "R2");
    shifts(10, "R4");

    // R6, R8: split into the upper half, tap bit 8 ignored (300 -> offset 44)
    step(1, 1, 1, 9, 300, 0, "R6");
    shifts(4, "R6");
    shifts(252, "R8");
    shifts(3, "R8");

    // R5: disabled strobe does nothing
    step(1, 0, 0, 12, 5, 0, "R5");
    step(1, 0, 1, 13, 6, 0, "R5");
    shifts(4, "R5");

    // R10: full transfer collides with a serial rise
    step(1, 1, 0, 20, 100, 1, "R10");
    step(0, 0, 0, 0, 0, 0, "R10");
    shifts(3, "R10");

    // R11: split transfer collides with the boundary step
    step(1, 1, 0, 2, 254, 0, "R11");
    shifts(1, "R11");
    step(1, 1, 1, 11, 17, 1, "R11");
    step(0, 0, 0, 0, 0, 0, "R11");
    shifts(5, "R11");

    // Constrained random mix, taps biased near the half boundary
    for (int i = 0; i < 6000; i++) begin
      bit stb;
      stb = ($urandom % 60) == 0;
      tap = ($urandom % 2) ? (240 + $urandom % 16 + 256 * ($urandom % 2)) : ($urandom % 512);
      step(stb, ($urandom % 5) != 0, ($urandom % 4) != 0, $urandom % 512, tap,
           1'($urandom % 2), "R2/R6/R8/R9/R11");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule